// File: doc/BRIEF.md
# Error-detecting refresh controller

This block drives the periodic refresh of a row-organised bit array and uses each refresh walk to check that the array has not changed. A signature register, the test characteristic, is built one row per cycle while a row counter steps through every row. Each row is read, folded into the signature, and written back unchanged. When the last row has been folded in, the signature is compared with a reference characteristic, and any difference sets a sticky error flag.

The characteristic of the whole array is the bitwise XOR of the addresses `{row, col}` of every cell that holds a 1. Host writes keep the reference up to date without a new full scan. The old row is folded into the reference, the written row is folded in again, and the difference between the two is the address of the changed cell.

A write can arrive while a pass is running. If the pass has already covered that row, the test characteristic receives the same correction. When the array does not start out all zero, a learn pass builds the reference from the current contents. The array itself lies outside the block and is reached through a row port that reads combinationally and writes one full row per cycle.

Top module: `edr_refresh_ctrl`

## Requirements
- R1: After reset `err_o`, `host_ack_o`, `busy_o` and `arr_we_o` are 0. The reference and test characteristics are zero, which matches an all-zero array.
- R2: A `refresh_tick_i` pulse starts a pass. `busy_o` is 1 for the whole pass. Rows 0 to ROWS-1 are each visited once in ascending order, and each row is written back with the data just read.
- R3: The characteristic is the XOR of `{row, col}` over all cells that hold 1. At the end of a pass the test value is compared with the reference. A mismatch sets `err_o`, so a single flipped cell at a nonzero address is detected and a flip of two cells is detected. A flip at address 0 leaves both characteristics equal and raises no error.
- R4: A host write (`host_we_i`=1) takes two cycles after acceptance. The first reads the old row. The second writes the row back with bit `host_col_i` replaced by `host_wdata_i`, pulses `host_ack_o`, and corrects the reference, so the next pass reports no error.
- R5: A write during a pass to a row below the current refresh position also corrects the test characteristic, and the pass ends without error.
- R6: A write during a pass to a row at or above the current refresh position corrects only the reference, and the pass ends without error.
- R7: A host request takes priority over a refresh step. The pass then resumes at the saved row, with no row skipped or repeated.
- R8: A `learn_i` pulse runs a pass that rebuilds the reference from the array contents. Host requests are held off until that pass ends. A later refresh pass over the unchanged array reports no error.
- R9: `err_o` stays set until `err_clr_i` is asserted. The test characteristic is cleared at the start of every pass.
- R10: A host read (`host_we_i`=0) returns bit `host_col_i` of row `host_row_i` on `host_rdata_o` in the cycle where `host_ack_o` is 1. `host_ack_o` is a single-cycle pulse.
- R11: A refresh tick that arrives while a pass is running is remembered, and another pass starts once the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| refresh_tick_i | input | 1 | Request one refresh-and-check pass |
| learn_i | input | 1 | Request one pass that rebuilds the reference |
| host_req_i | input | 1 | Host request, held until acknowledged |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_row_i | input | RW | Host row address |
| host_col_i | input | CW | Host column address |
| host_wdata_i | input | 1 | Host write bit |
| host_ack_o | output | 1 | Request completed |
| host_rdata_o | output | 1 | Read bit, valid with ack |
| err_clr_i | input | 1 | Clear the sticky error |
| err_o | output | 1 | Sticky consistency error |
| busy_o | output | 1 | Pass in progress |
| arr_row_o | output | RW | Array row address |
| arr_rdata_i | input | COLS | Array row read data (combinational) |
| arr_we_o | output | 1 | Array row write enable |
| arr_wdata_o | output | COLS | Array row write data |

## Verification
The bench builds the block with 8 rows and 8 columns, so a pass lasts only about ten cycles. With so few cycles, host writes can be placed on either side of the refresh position in the middle of a pass, including on the row whose step was pre-empted. The narrow addresses also keep the expected results easy to follow. Address 0 is shown to be invisible. A two-bit flip within one row is caught through the column part alone, because the even parity clears the row part. The array model belongs to the bench, which flips cells directly to stand in for soft errors.

// File: rtl/edr_pkg.sv
package edr_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_WR_OLD = 2'd1,
    ST_WR_NEW = 2'd2,
    ST_RD     = 2'd3
  } edr_state_e;
endpackage

// File: rtl/edr_row_comp.sv
module edr_row_comp #(
  parameter  int ROWS = 64,
  parameter  int COLS = 64,
  localparam int RW   = $clog2(ROWS),
  localparam int CW   = $clog2(COLS),
  localparam int SW   = RW + CW
) (
  input  logic [RW-1:0]   row_i,
  input  logic [COLS-1:0] data_i,
  output logic [SW-1:0]   char_o
);

  function automatic logic [COLS-1:0] col_mask(input int b);
    logic [COLS-1:0] m;
    for (int c = 0; c < COLS; c++) m[c] = ((c >> b) & 1) == 1;
    return m;
  endfunction

  logic [CW-1:0] colx;
  logic          par;

  // one parity tree per column-address bit
  for (genvar gi = 0; gi < CW; gi++) begin : g_colbit
    assign colx[gi] = ^(data_i & col_mask(gi));
  end

  assign par    = ^data_i;
  assign char_o = {par ? row_i : {RW{1'b0}}, colx};

endmodule

// File: rtl/edr_sig.sv
module edr_sig #(
  parameter int SW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] char_i,
  input  logic          start_test_i,
  input  logic          start_ref_i,
  input  logic          step_test_i,
  input  logic          step_ref_i,
  input  logic          last_i,
  input  logic          hold_old_i,
  input  logic          wr_apply_i,
  input  logic          wr_cov_i,
  input  logic          err_clr_i,
  output logic          err_o
);

  logic [SW-1:0] refc_q, testc_q, old_q;
  logic          err_q;
  logic [SW-1:0] wr_delta;
  logic          mismatch;

  assign wr_delta = old_q ^ char_i;
  assign mismatch = (testc_q ^ char_i) != refc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      refc_q  <= '0;
      testc_q <= '0;
      old_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      if (start_ref_i)      refc_q <= '0;
      else if (step_ref_i)  refc_q <= refc_q ^ char_i;
      else if (wr_apply_i)  refc_q <= refc_q ^ wr_delta;

      if (start_test_i)                testc_q <= '0;
      else if (step_test_i)            testc_q <= testc_q ^ char_i;
      else if (wr_apply_i && wr_cov_i) testc_q <= testc_q ^ wr_delta;

      if (hold_old_i) old_q <= char_i;

      if (step_test_i && last_i && mismatch) err_q <= 1'b1;
      else if (err_clr_i)                    err_q <= 1'b0;
    end
  end

  assign err_o = err_q;

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !err_clr_i |=> err_q);

  // R9
  test_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_test_i |=> testc_q == '0);

  // R3
  err_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(step_test_i && last_i));

endmodule

// File: rtl/edr_seq.sv
module edr_seq
  import edr_pkg::*;
#(
  parameter  int ROWS = 64,
  parameter  int COLS = 64,
  localparam int RW   = $clog2(ROWS),
  localparam int CW   = $clog2(COLS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            refresh_tick_i,
  input  logic            learn_i,
  input  logic            host_req_i,
  input  logic            host_we_i,
  input  logic [RW-1:0]   host_row_i,
  input  logic [CW-1:0]   host_col_i,
  input  logic            host_wdata_i,
  output logic            host_ack_o,
  output logic            host_rdata_o,
  output logic            busy_o,
  output logic [RW-1:0]   arr_row_o,
  input  logic [COLS-1:0] arr_rdata_i,
  output logic            arr_we_o,
  output logic [COLS-1:0] arr_wdata_o,
  output logic [RW-1:0]   comp_row_o,
  output logic [COLS-1:0] comp_data_o,
  output logic            start_test_o,
  output logic            start_ref_o,
  output logic            step_test_o,
  output logic            step_ref_o,
  output logic            last_o,
  output logic            hold_old_o,
  output logic            wr_apply_o,
  output logic            wr_cov_o
);

  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  edr_state_e      state_q;
  logic [RW-1:0]   cnt_q, row_q;
  logic [CW-1:0]   col_q;
  logic            wdata_q, busy_q, learn_q, tick_pend_q, learn_pend_q;
  logic            accept, step, start;
  logic [COLS-1:0] new_row;

  // host wins over a refresh step, except during a learn pass
  assign accept = (state_q == ST_RUN) && host_req_i && !(busy_q && learn_q);
  assign step   = (state_q == ST_RUN) && busy_q && !accept;
  assign start  = (state_q == ST_RUN) && !busy_q && !accept && (tick_pend_q || learn_pend_q);
  assign last_o = step && (cnt_q == LAST_ROW);

  always_comb begin
    new_row        = arr_rdata_i;
    new_row[col_q] = wdata_q;
  end

  always_comb begin
    arr_row_o   = row_q;
    arr_we_o    = 1'b0;
    arr_wdata_o = arr_rdata_i;
    comp_row_o  = row_q;
    comp_data_o = arr_rdata_i;
    unique case (state_q)
      ST_RUN: begin
        arr_row_o  = cnt_q;
        arr_we_o   = step;
        comp_row_o = cnt_q;
      end
      ST_WR_NEW: begin
        arr_we_o    = 1'b1;
        arr_wdata_o = new_row;
        comp_data_o = new_row;
      end
      default: ;
    endcase
  end

  assign host_ack_o   = (state_q == ST_WR_NEW) || (state_q == ST_RD);
  assign host_rdata_o = (state_q == ST_RD) && arr_rdata_i[col_q];
  assign busy_o       = busy_q;

  assign start_test_o = start && !learn_pend_q;
  assign start_ref_o  = start && learn_pend_q;
  assign step_test_o  = step && !learn_q;
  assign step_ref_o   = step && learn_q;
  assign hold_old_o   = state_q == ST_WR_OLD;
  assign wr_apply_o   = state_q == ST_WR_NEW;
  assign wr_cov_o     = busy_q && !learn_q && (row_q < cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_RUN;
      cnt_q        <= '0;
      row_q        <= '0;
      col_q        <= '0;
      wdata_q      <= 1'b0;
      busy_q       <= 1'b0;
      learn_q      <= 1'b0;
      tick_pend_q  <= 1'b0;
      learn_pend_q <= 1'b0;
    end else begin
      tick_pend_q  <= (tick_pend_q && !(start && !learn_pend_q)) || refresh_tick_i;
      learn_pend_q <= (learn_pend_q && !start) || learn_i;
      unique case (state_q)
        ST_RUN: begin
          if (accept) begin
            row_q   <= host_row_i;
            col_q   <= host_col_i;
            wdata_q <= host_wdata_i;
            state_q <= host_we_i ? ST_WR_OLD : ST_RD;
          end else if (step) begin
            cnt_q <= last_o ? '0 : cnt_q + 1'b1;
            if (last_o) busy_q <= 1'b0;
          end else if (start) begin
            busy_q  <= 1'b1;
            cnt_q   <= '0;
            learn_q <= learn_pend_q;
          end
        end
        ST_WR_OLD: state_q <= ST_WR_NEW;
        default:   state_q <= ST_RUN;
      endcase
    end
  end

  // R7
  pass_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(cnt_q) == LAST_ROW);

  // R8
  learn_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && learn_q |-> !host_ack_o);

  // R10
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ack_o |=> !host_ack_o);

  // R4
  wr_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ack_o && arr_we_o |-> $past(state_q) == ST_WR_OLD);

endmodule

// File: rtl/edr_refresh_ctrl.sv
module edr_refresh_ctrl #(
  parameter  int ROWS = 64,
  parameter  int COLS = 64,
  localparam int RW   = $clog2(ROWS),
  localparam int CW   = $clog2(COLS),
  localparam int SW   = RW + CW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            refresh_tick_i,
  input  logic            learn_i,
  input  logic            host_req_i,
  input  logic            host_we_i,
  input  logic [RW-1:0]   host_row_i,
  input  logic [CW-1:0]   host_col_i,
  input  logic            host_wdata_i,
  output logic            host_ack_o,
  output logic            host_rdata_o,
  input  logic            err_clr_i,
  output logic            err_o,
  output logic            busy_o,
  output logic [RW-1:0]   arr_row_o,
  input  logic [COLS-1:0] arr_rdata_i,
  output logic            arr_we_o,
  output logic [COLS-1:0] arr_wdata_o
);

  logic [RW-1:0]   comp_row;
  logic [COLS-1:0] comp_data;
  logic [SW-1:0]   row_char;
  logic start_test, start_ref, step_test, step_ref, last, hold_old, wr_apply, wr_cov;

  edr_seq #(.ROWS(ROWS), .COLS(COLS)) u_seq (
    .clk_i, .rst_ni, .refresh_tick_i, .learn_i,
    .host_req_i, .host_we_i, .host_row_i, .host_col_i, .host_wdata_i,
    .host_ack_o, .host_rdata_o, .busy_o,
    .arr_row_o, .arr_rdata_i, .arr_we_o, .arr_wdata_o,
    .comp_row_o   (comp_row),
    .comp_data_o  (comp_data),
    .start_test_o (start_test),
    .start_ref_o  (start_ref),
    .step_test_o  (step_test),
    .step_ref_o   (step_ref),
    .last_o       (last),
    .hold_old_o   (hold_old),
    .wr_apply_o   (wr_apply),
    .wr_cov_o     (wr_cov)
  );

  edr_row_comp #(.ROWS(ROWS), .COLS(COLS)) u_comp (
    .row_i  (comp_row),
    .data_i (comp_data),
    .char_o (row_char)
  );

  edr_sig #(.SW(SW)) u_sig (
    .clk_i, .rst_ni,
    .char_i       (row_char),
    .start_test_i (start_test),
    .start_ref_i  (start_ref),
    .step_test_i  (step_test),
    .step_ref_i   (step_ref),
    .last_i       (last),
    .hold_old_i   (hold_old),
    .wr_apply_i   (wr_apply),
    .wr_cov_i     (wr_cov),
    .err_clr_i,
    .err_o
  );

endmodule

// File: tb/edr_refresh_ctrl_bench.sv
module edr_refresh_ctrl_bench;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int RW   = $clog2(ROWS);
  localparam int CW   = $clog2(COLS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, learn = 1'b0, req = 1'b0, we = 1'b0, wd = 1'b0, err_clr = 1'b0;
  logic [RW-1:0] hrow = '0;
  logic [CW-1:0] hcol = '0;
  logic host_ack, host_rdata, err, busy, arr_we;
  logic [RW-1:0]   arr_row;
  logic [COLS-1:0] arr_rdata, arr_wdata;

  logic [COLS-1:0] mem [ROWS];
  logic            inj_en = 1'b0;
  logic [RW-1:0]   inj_row = '0;
  logic [COLS-1:0] inj_mask = '0;

  int total = 0, bad = 0;
  int steps_seen = 0, order_bad = 0;
  logic [RW-1:0] exp_row = '0;
  logic busy_prev = 1'b0;

  always #4 clk = ~clk;

  edr_refresh_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_edr_refresh_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .refresh_tick_i(tick), .learn_i(learn),
    .host_req_i(req), .host_we_i(we), .host_row_i(hrow), .host_col_i(hcol),
    .host_wdata_i(wd), .host_ack_o(host_ack), .host_rdata_o(host_rdata),
    .err_clr_i(err_clr), .err_o(err), .busy_o(busy),
    .arr_row_o(arr_row), .arr_rdata_i(arr_rdata), .arr_we_o(arr_we), .arr_wdata_o(arr_wdata)
  );

  // array model; inj_* flips cells to model soft errors
  assign arr_rdata = mem[arr_row];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) mem[i] <= '0;
    end else begin
      if (arr_we) mem[arr_row] <= arr_wdata;
      if (inj_en) mem[inj_row] <= mem[inj_row] ^ inj_mask;
    end
  end

  // refresh step monitor: order and write-back data
  always @(negedge clk) begin
    if (busy && !busy_prev) begin
      steps_seen = 0;
      exp_row    = '0;
    end
    busy_prev = busy;
    if (rst_n && arr_we && !host_ack) begin
      if (arr_row != exp_row || arr_wdata != arr_rdata) order_bad++;
      exp_row = exp_row + 1'b1;
      steps_seen++;
    end
  end

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic wait_busy();
    do @(negedge clk); while (!busy);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic inject(input int r, input logic [COLS-1:0] m);
    @(negedge clk); inj_en = 1'b1; inj_row = RW'(r); inj_mask = m;
    @(negedge clk); inj_en = 1'b0;
  endtask

  task automatic host_write(input int r, input int c, input logic b);
    @(negedge clk); req = 1'b1; we = 1'b1; hrow = RW'(r); hcol = CW'(c); wd = b;
    do @(negedge clk); while (!host_ack);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic host_read(input int r, input int c, output logic b);
    @(negedge clk); req = 1'b1; we = 1'b0; hrow = RW'(r); hcol = CW'(c);
    do @(negedge clk); while (!host_ack);
    b = host_rdata;
    req = 1'b0;
  endtask

  task automatic run_pass(input string tag);
    int ob0;
    ob0 = order_bad;
    pulse_tick();
    wait_busy();
    wait_idle();
    chk(steps_seen == ROWS, {"R2 step count ", tag}, steps_seen, ROWS);
    chk(order_bad == ob0, {"R2 order/writeback ", tag}, order_bad - ob0, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(err == 1'b0, "R1 err", err, 0);
    chk(host_ack == 1'b0, "R1 ack", host_ack, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(arr_we == 1'b0, "R1 arr_we", arr_we, 0);
  endtask

  task automatic t_clean_pass();
    int nz;
    run_pass("clean");
    chk(err == 1'b0, "R3 clean pass err", err, 0);
    nz = 0;
    for (int i = 0; i < ROWS; i++) if (mem[i] != '0) nz++;
    chk(nz == 0, "R2 contents unchanged", nz, 0);
  endtask

  task automatic t_writes();
    logic b;
    host_write(2, 5, 1'b1);
    host_write(7, 0, 1'b1);
    host_write(0, 3, 1'b1);
    host_write(7, 7, 1'b1);
    @(negedge clk);
    chk(mem[2] == 8'h20, "R4 row 2 written", mem[2], 8'h20);
    chk(mem[7] == 8'h81, "R4 row 7 written", mem[7], 8'h81);
    host_read(2, 5, b);
    chk(b == 1'b1, "R10 read set bit", b, 1);
    host_read(2, 4, b);
    chk(b == 1'b0, "R10 read clear bit", b, 0);
    host_write(2, 5, 1'b1);
    run_pass("after writes");
    chk(err == 1'b0, "R4 ref tracks writes", err, 0);
    host_write(7, 0, 1'b0);
    run_pass("after clear write");
    chk(err == 1'b0, "R4 ref tracks 1->0 write", err, 0);
  endtask

  task automatic t_flip();
    inject(5, 8'h08);
    run_pass("flip");
    chk(err == 1'b1, "R3 single flip detected", err, 1);
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R9 err sticky", err, 1);
    run_pass("flip again");
    chk(err == 1'b1, "R9 still set", err, 1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk(err == 1'b0, "R9 err cleared", err, 0);
    inject(5, 8'h08);
    run_pass("restored");
    chk(err == 1'b0, "R9 test cleared per pass", err, 0);
  endtask

  task automatic t_addr0_and_double();
    inject(0, 8'h01);
    run_pass("addr0");
    chk(err == 1'b0, "R3 address 0 invisible", err, 0);
    inject(0, 8'h01);
    inject(3, 8'h06);
    run_pass("double");
    chk(err == 1'b1, "R3 double flip detected", err, 1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    inject(3, 8'h06);
    run_pass("double restored");
    chk(err == 1'b0, "R3 restored clean", err, 0);
  endtask

  task automatic t_write_mid_pass();
    int ob0;
    ob0 = order_bad;
    pulse_tick();
    wait_busy();
    while (!(arr_we && !host_ack && arr_row == RW'(4))) @(negedge clk);
    host_write(7, 2, 1'b1);   // not yet covered
    host_write(1, 6, 1'b1);   // already covered
    host_write(3, 4, 1'b1);   // already covered
    wait_idle();
    chk(err == 1'b0, "R5/R6 mid-pass writes no false error", err, 0);
    chk(steps_seen == ROWS, "R7 pass resumed, all rows", steps_seen, ROWS);
    chk(order_bad == ob0, "R7 no skip or repeat", order_bad - ob0, 0);
    chk(mem[1][6] == 1'b1, "R5 covered row written", mem[1][6], 1);
    chk(mem[7][2] == 1'b1, "R6 uncovered row written", mem[7][2], 1);
    run_pass("post mid");
    chk(err == 1'b0, "R5 ref consistent next pass", err, 0);
  endtask

  task automatic t_tick_during_pass();
    pulse_tick();
    wait_busy();
    pulse_tick();
    wait_idle();
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R11 queued tick starts pass", busy, 1);
    wait_idle();
    chk(err == 1'b0, "R11 queued pass clean", err, 0);
  endtask

  task automatic t_learn();
    logic b, exp_b;
    int overlap;
    inject(3, 8'h5A);
    inject(6, 8'h81);
    @(negedge clk); learn = 1'b1;
    @(negedge clk); learn = 1'b0;
    wait_busy();
    overlap = 0;
    exp_b = mem[3][1];
    @(negedge clk); req = 1'b1; we = 1'b0; hrow = RW'(3); hcol = CW'(1);
    do begin
      @(negedge clk);
      if (busy && host_ack) overlap++;
    end while (!host_ack);
    b = host_rdata;
    req = 1'b0;
    chk(overlap == 0, "R8 host held during learn", overlap, 0);
    chk(b == exp_b, "R10 read after learn", b, exp_b);
    run_pass("after learn");
    chk(err == 1'b0, "R8 learned reference matches", err, 0);
    inject(6, 8'h10);
    run_pass("learn flip");
    chk(err == 1'b1, "R8 flip after learn detected", err, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_clean_pass();
    t_writes();
    t_flip();
    t_addr0_and_double();
    t_write_mid_pass();
    t_tick_during_pass();
    t_learn();
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule